// File: doc/BRIEF.md
# Configurable UART Serial Transmitter

This block serialises bytes onto an asynchronous serial line. A one-byte holding register accepts a byte on a write strobe. When the shift engine is free, the byte moves from the holding register into it and goes out as one start bit, then 5 to 8 data bits with the LSB first, an optional parity bit, and a stop period of 1, 1.5 or 2 bit times. The idle line is at logic 1.

Line settings are plain inputs: the character length, the stop-bit choice, parity enable, the parity mode and a break override. The transmitter takes a snapshot of every setting except break at the moment a character enters the shift engine. Break acts on the output pin at once. The bit clock comes from a 16x oversampling tick. The tick period is a 16-bit divisor counted in input-clock cycles, so the divisor is the clock frequency divided by 16 times the baud rate.

Two flags report progress. One shows that the holding register is free. The other shows that both the holding register and the shift engine are empty, so the line is idle.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, and whenever the transmitter is empty and break is off, `txd` is 1, and `thr_empty` and `tx_empty` are both 1.
- R2: A character is a start bit at 0, then the data bits LSB first. `cfg_len` gives the data length: 00 is 5 bits, 01 is 6, 10 is 7 and 11 is 8. Data bits above the selected length are not sent. Every start, data and parity bit lasts 16 ticks.
- R3: With `cfg_par_en`=1, one parity bit follows the last data bit. `cfg_par_sel` sets its value. With 00 (odd), the data bits and the parity bit together hold an odd number of ones. With 01 (even), they hold an even number of ones. With 10 the bit is 1, and with 11 it is 0. With `cfg_par_en`=0, no parity bit is sent.
- R4: The stop period is at logic 1. It lasts 16 ticks when `cfg_two_stop`=0. It lasts 32 ticks when `cfg_two_stop`=1, except with `cfg_len`=00, where it lasts 24 ticks.
- R5: While `cfg_break` is 1, `txd` is 0 in the same cycle, whether a character is in progress or the line is idle. Break does not change the timing of a character in progress, and it does not change the flags.
- R6: `thr_empty` goes to 0 in the cycle after a write. It returns to 1 in the cycle after the byte moves into the shift engine. A write made while the holding register is already full replaces the waiting byte, and the replaced byte is never sent.
- R7: `tx_empty` is 1 only when the holding register and the shift engine are both empty. It rises in the cycle after the stop period of the last character ends.
- R8: A byte waiting in the holding register starts at the edge that ends the stop period of the current character. Its start bit follows the stop period with no idle cycles between them.
- R9: One tick lasts `divisor` clock cycles. A `divisor` of 0 gives the same timing as 1.
- R10: Length, stop and parity settings are sampled when a character enters the shift engine. Changes to them during that character affect only later characters.
- R11: When the transmitter is idle, the start bit appears on `txd` one clock after the edge that captures the write. From that cycle the character lasts exactly its frame length in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| cfg_len | input | 2 | Data length code (00 gives 5 bits through 11 gives 8 bits) |
| cfg_two_stop | input | 1 | Longer stop period select |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_sel | input | 2 | Parity mode: odd, even, forced 1 or forced 0 |
| cfg_break | input | 1 | Force the line to 0 |
| divisor | input | 16 | Tick period in clock cycles |
| txd | output | 1 | Serial output |
| thr_empty | output | 1 | Holding register is free |
| tx_empty | output | 1 | Holding register and shift engine are both empty |

## Verification
Some behaviours are checked by assertions on every cycle. The line stays high whenever the engine is idle or in its stop period. A loaded character starts with a low start bit on the next cycle. The holding register keeps its byte until the engine takes it. A waiting byte is taken at the end of a stop period with no gap, and ticks never come on two cycles in a row unless the divisor is 1. Other behaviours need the bench's scenarios. These are the bit values and the exact stop lengths, including the 1.5 case, the four parity modes, and snapshot behaviour when settings change mid-character. They also include the byte that is dropped when a waiting byte is replaced, break during a character and the treatment of a zero divisor.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef struct packed {
      logic [1:0] len;
      logic       two_stop;
      logic       par_en;
      logic [1:0] par_sel;
   } line_cfg_t;

   typedef enum logic [1:0] {
      PAR_ODD  = 2'b00,
      PAR_EVEN = 2'b01,
      PAR_ONE  = 2'b10,
      PAR_ZERO = 2'b11
   } par_mode_e;

   // number of data bits for a length code
   function automatic logic [3:0] char_bits(input logic [1:0] len);
      return 4'd5 + {2'b00, len};
   endfunction

   // parity bit over already-masked data
   function automatic logic par_bit(input logic [7:0] masked, input logic [1:0] sel);
      case (par_mode_e'(sel))
         PAR_ODD:  return ~^masked;
         PAR_EVEN: return ^masked;
         PAR_ONE:  return 1'b1;
         default:  return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/uart_tx_tick.sv
module uart_tx_tick #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] div_eff;

   initial assert (DIV_W >= 2) else $error("DIV_W too small");

   // zero divisor behaves as one so the tick never stalls
   assign div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
   assign tick    = run && (cnt >= div_eff - DIV_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                   cnt <= cnt + DIV_W'(1);
   end

   // R9: with a stable divisor above one, ticks are never adjacent
   a_r9_no_double_tick: assert property (@(posedge clk) disable iff (!rst_n)
      tick && (div_eff != DIV_W'(1)) && $stable(divisor) |=> !tick);

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              hold_valid,
   output logic [DATA_W-1:0] hold_data
);
   initial assert (DATA_W >= 5) else $error("DATA_W must cover 5-bit characters");

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_data  <= '0;
      end else begin
         if (wr_en) begin
            hold_valid <= 1'b1;
            hold_data  <= wr_data;
         end else if (take) begin
            hold_valid <= 1'b0;
         end
      end
   end

   // R6: a waiting byte stays until the engine takes it
   a_r6_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
      hold_valid && !take |=> hold_valid);

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
   import uart_tx_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      load,
   input  logic [7:0] data,
   input  line_cfg_t cfg,
   output logic      busy,
   output logic      line_bit,
   output logic      frame_done
);
   localparam int CNT_W = $clog2(2 * OSR + 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] stop_len;
   logic [CNT_W-1:0] stop_new;
   logic [CNT_W-1:0] limit;
   logic             in_stop;
   logic [3:0]       nleft;
   logic [3:0]       nbits_new;
   logic [3:0]       n;
   logic [8:0]       sh;
   logic [8:0]       frame_vec;
   logic [7:0]       masked;
   logic             pbit;
   logic             bit_end;

   initial assert (OSR >= 2 && (OSR % 2) == 0) else $error("OSR must be even and >= 2");

   assign n = char_bits(cfg.len);

   for (genvar i = 0; i < 8; i++) begin : g_mask
      assign masked[i] = data[i] & (n > 4'(i));
   end

   assign pbit = par_bit(masked, cfg.par_sel);

   always_comb begin
      frame_vec = {1'b1, masked};
      if (cfg.par_en) frame_vec[n] = pbit;
   end

   assign nbits_new = n + {3'b000, cfg.par_en};

   always_comb begin
      if (!cfg.two_stop)         stop_new = CNT_W'(OSR);
      else if (cfg.len == 2'b00) stop_new = CNT_W'(OSR + OSR / 2);
      else                       stop_new = CNT_W'(2 * OSR);
   end

   assign limit      = in_stop ? stop_len : CNT_W'(OSR);
   assign bit_end    = busy && tick && (cnt == limit - CNT_W'(1));
   assign frame_done = bit_end && in_stop;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         line_bit <= 1'b1;
         cnt      <= '0;
         stop_len <= CNT_W'(OSR);
         in_stop  <= 1'b0;
         nleft    <= '0;
         sh       <= '1;
      end else if (load) begin
         busy     <= 1'b1;
         line_bit <= 1'b0;
         sh       <= frame_vec;
         nleft    <= nbits_new;
         in_stop  <= 1'b0;
         cnt      <= '0;
         stop_len <= stop_new;
      end else if (frame_done) begin
         busy     <= 1'b0;
         in_stop  <= 1'b0;
         cnt      <= '0;
         line_bit <= 1'b1;
      end else if (bit_end) begin
         cnt <= '0;
         if (nleft != 4'd0) begin
            line_bit <= sh[0];
            sh       <= {1'b1, sh[8:1]};
            nleft    <= nleft - 4'd1;
         end else begin
            in_stop  <= 1'b1;
            line_bit <= 1'b1;
         end
      end else if (busy && tick) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   // R11: a load puts a start bit on the line at the next cycle
   a_r11_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy && !line_bit);

   // R1: idle engine drives a high line
   a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> line_bit);

   // R4: stop period is high
   a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
      in_stop |-> line_bit);

   // R2: tick count stays inside the current bit
   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cnt < limit);

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
   import uart_tx_pkg::*;
#(
   parameter int OSR   = 16,
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic [1:0]       cfg_len,
   input  logic             cfg_two_stop,
   input  logic             cfg_par_en,
   input  logic [1:0]       cfg_par_sel,
   input  logic             cfg_break,
   input  logic [DIV_W-1:0] divisor,
   output logic             txd,
   output logic             thr_empty,
   output logic             tx_empty
);
   line_cfg_t  cfg;
   logic       tick;
   logic       busy;
   logic       line_bit;
   logic       frame_done;
   logic       hold_valid;
   logic [7:0] hold_data;
   logic       load;

   assign cfg = '{len: cfg_len, two_stop: cfg_two_stop, par_en: cfg_par_en, par_sel: cfg_par_sel};

   // the engine takes a waiting byte when free or at the end of its stop period
   assign load = hold_valid && (!busy || frame_done);

   uart_tx_tick #(.DIV_W(DIV_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .divisor (divisor),
      .tick    (tick)
   );

   uart_tx_hold #(.DATA_W(8)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .take       (load),
      .hold_valid (hold_valid),
      .hold_data  (hold_data)
   );

   uart_tx_shift #(.OSR(OSR)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .load       (load),
      .data       (hold_data),
      .cfg        (cfg),
      .busy       (busy),
      .line_bit   (line_bit),
      .frame_done (frame_done)
   );

   assign txd       = cfg_break ? 1'b0 : line_bit;
   assign thr_empty = !hold_valid;
   assign tx_empty  = !hold_valid && !busy;

   // R7: an empty transmitter leaves the line idle unless break is on
   a_r7_empty_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty && !cfg_break |-> txd);

   // R8: a waiting byte starts right at the end of the stop period
   a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done && hold_valid && !wr_en |=> busy && thr_empty);

   // R6: a write always leaves the holding register occupied
   a_r6_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !thr_empty);

endmodule

// File: tb/uart_tx_core_bench.sv
`timescale 1ns/1ps
module uart_tx_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [1:0]  cfg_len = 2'b11;
   logic        cfg_two_stop = 1'b0;
   logic        cfg_par_en = 1'b0;
   logic [1:0]  cfg_par_sel = 2'b00;
   logic        cfg_break = 1'b0;
   logic [15:0] divisor = 16'd1;
   logic        txd, thr_empty, tx_empty;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   uart_tx_core u_uart_tx_core (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .cfg_len(cfg_len), .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
      .cfg_par_sel(cfg_par_sel), .cfg_break(cfg_break), .divisor(divisor),
      .txd(txd), .thr_empty(thr_empty), .tx_empty(tx_empty)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int k);
      repeat (k) @(negedge clk);
   endtask

   function automatic int nbits(input logic [1:0] len);
      return 5 + int'(len);
   endfunction

   function automatic logic exp_par(input logic [7:0] d, input logic [1:0] len, input logic [1:0] sel);
      int ones = 0;
      for (int i = 0; i < nbits(len); i++) ones += int'(d[i]);
      case (sel)
         2'b00: return (ones % 2 == 0);
         2'b01: return (ones % 2 == 1);
         2'b10: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic int stop_ticks(input logic [1:0] len, input logic two);
      if (!two) return 16;
      if (len == 2'b00) return 24;
      return 32;
   endfunction

   // starts at a negedge that lies el0 cycles after the start-bit negedge
   task automatic check_frame(input logic [7:0] d, input logic [1:0] len, input logic two,
                              input logic pen, input logic [1:0] psel, input int dv,
                              input int el0, input bit more);
      int de = (dv == 0) ? 1 : dv;
      int nd = nbits(len);
      int nt = nd + int'(pen);
      int el = el0;
      int tend;
      logic e;
      for (int j = 1; j <= nt; j++) begin
         step(16 * de * j + 8 * de - el);
         el = 16 * de * j + 8 * de;
         e = (j <= nd) ? d[j-1] : exp_par(d, len, psel);
         chk(txd == e, (j <= nd) ? "R2 data bit" : "R3 parity bit", int'(txd), int'(e));
      end
      step(16 * de * (1 + nt) + 8 * de - el);
      el = 16 * de * (1 + nt) + 8 * de;
      chk(txd == 1'b1, "R4 stop level", int'(txd), 1);
      tend = 16 * de * (1 + nt) + stop_ticks(len, two) * de;
      step(tend - 1 - el);
      chk(tx_empty == 1'b0 && txd == 1'b1, "R4 stop not yet over", int'(tx_empty), 0);
      step(1);
      if (!more) begin
         chk(tx_empty == 1'b1, "R7 empty after stop", int'(tx_empty), 1);
         chk(txd == 1'b1, "R1 idle line", int'(txd), 1);
      end else begin
         chk(txd == 1'b0, "R8 next start without gap", int'(txd), 0);
         chk(thr_empty == 1'b1, "R6 holding freed at reload", int'(thr_empty), 1);
      end
   endtask

   task automatic set_cfg(input logic [1:0] len, input logic two, input logic pen,
                          input logic [1:0] psel, input int dv);
      cfg_len = len; cfg_two_stop = two; cfg_par_en = pen; cfg_par_sel = psel;
      divisor = 16'(dv);
   endtask

   // one character from idle, ends at the negedge after the last stop cycle
   task automatic send(input logic [7:0] d, input logic [1:0] len, input logic two,
                       input logic pen, input logic [1:0] psel, input int dv, input bit scramble);
      set_cfg(len, two, pen, psel, dv);
      wr_data = d; wr_en = 1'b1;
      step(1);
      chk(thr_empty == 1'b0, "R6 holding full after write", int'(thr_empty), 0);
      wr_en = 1'b0;
      step(1);
      chk(txd == 1'b0, "R11 start one clock after write", int'(txd), 0);
      chk(thr_empty == 1'b1, "R6 holding freed on load", int'(thr_empty), 1);
      if (scramble) begin
         // R10: settings change after the snapshot
         cfg_len = 2'($urandom); cfg_two_stop = 1'($urandom);
         cfg_par_en = 1'($urandom); cfg_par_sel = 2'($urandom);
      end
      check_frame(d, len, two, pen, psel, dv, 0, 0);
   endtask

   initial begin
      step(3);
      chk(txd == 1'b1, "R1 reset txd", int'(txd), 1);
      chk(thr_empty == 1'b1, "R1 reset thr_empty", int'(thr_empty), 1);
      chk(tx_empty == 1'b1, "R1 reset tx_empty", int'(tx_empty), 1);
      rst_n = 1'b1;
      step(2);
      chk(txd == 1'b1 && tx_empty == 1'b1, "R1 idle after reset", int'(txd), 1);

      // directed: each length, stop choices incl. 1.5, parity modes
      send(8'hA5, 2'b11, 1'b0, 1'b0, 2'b00, 1, 0);
      send(8'hFF, 2'b00, 1'b1, 1'b0, 2'b00, 2, 0);   // R4 1.5 stop
      send(8'h3C, 2'b01, 1'b1, 1'b1, 2'b00, 1, 0);   // R3 odd
      send(8'h5A, 2'b10, 1'b0, 1'b1, 2'b01, 3, 0);   // R3 even
      send(8'h00, 2'b11, 1'b1, 1'b1, 2'b10, 1, 0);   // R3 forced one
      send(8'hFF, 2'b11, 1'b0, 1'b1, 2'b11, 2, 0);   // R3 forced zero
      send(8'hE0, 2'b00, 1'b0, 1'b0, 2'b00, 1, 0);   // R2 upper bits dropped
      send(8'h81, 2'b11, 1'b0, 1'b1, 2'b00, 0, 0);   // R9 divisor zero acts as one
      send(8'h6B, 2'b01, 1'b1, 1'b0, 2'b00, 4, 1);   // R10 mid-frame changes

      // R8: two bytes back to back
      set_cfg(2'b10, 1'b0, 1'b1, 2'b01, 2);
      wr_data = 8'h11; wr_en = 1'b1; step(1);
      wr_data = 8'h6E; step(1);
      wr_en = 1'b0;
      chk(thr_empty == 1'b0, "R8 second byte waiting", int'(thr_empty), 0);
      check_frame(8'h11, 2'b10, 1'b0, 1'b1, 2'b01, 2, 0, 1);
      check_frame(8'h6E, 2'b10, 1'b0, 1'b1, 2'b01, 2, 0, 0);

      // R6: replaced waiting byte is never sent
      set_cfg(2'b11, 1'b0, 1'b0, 2'b00, 1);
      wr_data = 8'hC3; wr_en = 1'b1; step(1);
      wr_data = 8'h0F; step(1);
      wr_data = 8'h96; step(1);
      wr_en = 1'b0;
      chk(thr_empty == 1'b0, "R6 overwrite keeps holding full", int'(thr_empty), 0);
      check_frame(8'hC3, 2'b11, 1'b0, 1'b0, 2'b00, 1, 1, 1);
      check_frame(8'h96, 2'b11, 1'b0, 1'b0, 2'b00, 1, 0, 0);

      // R5: break on an idle line
      cfg_break = 1'b1; #1;
      chk(txd == 1'b0, "R5 break idle", int'(txd), 0);
      chk(tx_empty == 1'b1, "R5 break leaves flags", int'(tx_empty), 1);
      step(1); cfg_break = 1'b0; #1;
      chk(txd == 1'b1, "R5 break released", int'(txd), 1);

      // R5: break in the middle of an all-ones character
      set_cfg(2'b11, 1'b0, 1'b0, 2'b00, 2);
      wr_data = 8'hFF; wr_en = 1'b1; step(1); wr_en = 1'b0; step(1);
      step(16 * 2 * 3 + 8 * 2);
      cfg_break = 1'b1; #1;
      chk(txd == 1'b0, "R5 break mid-frame", int'(txd), 0);
      step(1);
      chk(txd == 1'b0, "R5 break held", int'(txd), 0);
      cfg_break = 1'b0; #1;
      chk(txd == 1'b1, "R5 data resumes", int'(txd), 1);
      step(16 * 2 * 10 - 1 - (16 * 2 * 3 + 8 * 2 + 1));
      chk(tx_empty == 1'b0, "R5 timing kept", int'(tx_empty), 0);
      step(1);
      chk(tx_empty == 1'b1, "R5 frame ends on time", int'(tx_empty), 1);

      // random characters
      void'($urandom(32'd2024));
      for (int k = 0; k < 40; k++) begin
         send(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
              int'($urandom % 4), 1'($urandom));
      end

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule